// File: doc/BRIEF.md
# Smooth Clock Calibration Pulse Masker

This block trims the rate of a slow real-time clock enable, nominally 32.768 kHz, by a signed amount with sub-ppm resolution. It sits between the raw clock-enable and the asynchronous prescaler. Over each calibration window it removes a programmed number of enable pulses and, when asked, flags a fixed number of extra counts to the prescaler. The net change per window is 512 times the add bit minus the mask count, so any correction from -511 to +512 steps of about 0.954 ppm can be coded.

A window counter advances on every incoming enable. The add bit, the 9-bit mask count and the window length are all sampled on the first enable of each window and held until that window ends. Masked pulses are spread across the window by comparing the mask count against the bit-reversed slot index. Insertion pulses are spaced evenly, one per slot. For a positive correction k, code add=1 with mask=512-k. For a negative correction -k, code add=0 with mask=k. When the prescaler ratio is very small, the prescaler must absorb the extra counts, and that is the system's concern.

Top module: `cal_pulse_trim`

## Requirements
- R1: While rst_ni is low, ins_o is 0 and, with a zero mask count, tick_o equals tick_i. The window counter sits at the first position of a window.
- R2: With add_i=0 and mask_i=0, tick_o equals tick_i on every cycle and ins_o is never 1.
- R3: In a full window (win8_i=0, win16_i=0) of 2^WIN_LOG input enables, exactly mask_i enables are dropped from tick_o.
- R4: With add_i=1, ins_o pulses on exactly 2^MASK_W enables per full window, one every 2^(WIN_LOG-MASK_W) enables, and never on an enable that is dropped.
- R5: Dropped enables are spread evenly. With mask_i=256 in a full window, consecutive dropped enables are always 2^(WIN_LOG-MASK_W+1) enables apart.
- R6: win16_i=1 (with win8_i=0) selects a window of 2^(WIN_LOG-1) enables. Bit 0 of mask_i is ignored, so mask_i>>1 enables are dropped and 2^(MASK_W-1) insertions occur.
- R7: win8_i=1 selects a window of 2^(WIN_LOG-2) enables whatever win16_i is. The two low bits of mask_i are ignored, so mask_i>>2 enables are dropped and 2^(MASK_W-2) insertions occur.
- R8: add_i, mask_i, win8_i and win16_i are sampled on the first enable of a window. Changing them later in the window has no effect until the next window.
- R9: On cycles with tick_i=0 the window position does not move and both tick_o and ins_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Raw slow-clock enable |
| add_i | input | 1 | Add 2^MASK_W counts per full window |
| mask_i | input | MASK_W | Number of enables to drop per full window |
| win8_i | input | 1 | Select quarter-length window |
| win16_i | input | 1 | Select half-length window |
| tick_o | output | 1 | Corrected enable to the prescaler |
| ins_o | output | 1 | Extra-count request to the prescaler |

## Verification
On every cycle, the assertions check how the window counter moves. The counter holds while no enable arrives, steps by one on an enable and wraps to zero at the window's last position. They also check that the sampled settings stay frozen inside a window, and that a drop and an insertion never coincide. The counts per window, the even spacing, the bits ignored in short windows and the deferred effect of a change made mid-window are only visible over whole windows. These are shown by the bench's scenarios, which tally outputs per window against expected values.

// File: rtl/cal_trim_pkg.sv
package cal_trim_pkg;
  typedef enum logic [1:0] {
    WIN_FULL = 2'd0,
    WIN_HALF = 2'd1,
    WIN_QTR  = 2'd2
  } win_sel_e;

  // quarter window has priority over half window
  function automatic win_sel_e decode_win(input logic w8, input logic w16);
    if (w8)  return WIN_QTR;
    if (w16) return WIN_HALF;
    return WIN_FULL;
  endfunction
endpackage

// File: rtl/cal_win_ctr.sv
module cal_win_ctr
  import cal_trim_pkg::*;
#(
  parameter int WIN_LOG = 20,
  parameter int MASK_W  = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               add_i,
  input  logic [MASK_W-1:0]  mask_i,
  input  logic               win8_i,
  input  logic               win16_i,
  output logic [WIN_LOG-1:0] cnt_o,
  output logic               eff_add_o,
  output logic [MASK_W-1:0]  eff_mask_o,
  output logic [1:0]         eff_shift_o
);
  logic [WIN_LOG-1:0] cnt_q, hi_mask;
  logic               act_add_q;
  logic [MASK_W-1:0]  act_mask_q;
  logic [1:0]         act_shift_q, live_shift;
  logic               start, last;

  assign live_shift = 2'(decode_win(win8_i, win16_i));
  assign start      = (cnt_q == '0);

  // live settings apply on the window's first enable, held ones afterwards
  assign eff_add_o   = start ? add_i      : act_add_q;
  assign eff_mask_o  = start ? mask_i     : act_mask_q;
  assign eff_shift_o = start ? live_shift : act_shift_q;

  assign hi_mask = ~({WIN_LOG{1'b1}} >> eff_shift_o);
  assign last    = &(cnt_q | hi_mask);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      act_add_q   <= 1'b0;
      act_mask_q  <= '0;
      act_shift_q <= 2'd0;
    end else if (tick_i) begin
      cnt_q <= last ? '0 : cnt_q + WIN_LOG'(1);
      if (start) begin
        act_add_q   <= add_i;
        act_mask_q  <= mask_i;
        act_shift_q <= live_shift;
      end
    end
  end

  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !last) |=> (cnt_q == $past(cnt_q) + WIN_LOG'(1)));
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && last) |=> (cnt_q == '0));
  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !start) |=> ($stable(act_mask_q) && $stable(act_add_q) && $stable(act_shift_q)));
endmodule

// File: rtl/cal_slot_gen.sv
module cal_slot_gen #(
  parameter int WIN_LOG = 20,
  parameter int MASK_W  = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [WIN_LOG-1:0] cnt_i,
  input  logic               eff_add_i,
  input  logic [MASK_W-1:0]  eff_mask_i,
  input  logic [1:0]         eff_shift_i,
  output logic               drop_o,
  output logic               ins_o
);
  localparam int SUB_W = WIN_LOG - MASK_W;
  localparam logic [SUB_W-1:0] INS_POS = SUB_W'(1) << (SUB_W - 1);

  logic [MASK_W-1:0] slot, slot_rev, thr;
  logic [SUB_W-1:0]  sub;

  assign slot = cnt_i[WIN_LOG-1 -: MASK_W];
  assign sub  = cnt_i[SUB_W-1:0];

  for (genvar b = 0; b < MASK_W; b++) begin : g_rev
    assign slot_rev[b] = slot[MASK_W-1-b];
  end

  // short windows leave top slot bits at zero, so low threshold bits are dropped
  assign thr = eff_mask_i & ({MASK_W{1'b1}} << eff_shift_i);

  assign drop_o = tick_i && (sub == '0) && (slot_rev < thr);
  assign ins_o  = tick_i && eff_add_i && (sub == INS_POS);

  a_r4_no_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drop_o, ins_o}));
  a_r9_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> (!drop_o && !ins_o));
endmodule

// File: rtl/cal_pulse_trim.sv
module cal_pulse_trim #(
  parameter int WIN_LOG = 20,
  parameter int MASK_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              add_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              win8_i,
  input  logic              win16_i,
  output logic              tick_o,
  output logic              ins_o
);
  logic [WIN_LOG-1:0] cnt;
  logic               eff_add, drop;
  logic [MASK_W-1:0]  eff_mask;
  logic [1:0]         eff_shift;

  cal_win_ctr #(.WIN_LOG(WIN_LOG), .MASK_W(MASK_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .add_i(add_i), .mask_i(mask_i), .win8_i(win8_i), .win16_i(win16_i),
    .cnt_o(cnt), .eff_add_o(eff_add), .eff_mask_o(eff_mask), .eff_shift_o(eff_shift)
  );

  cal_slot_gen #(.WIN_LOG(WIN_LOG), .MASK_W(MASK_W)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_i(cnt),
    .eff_add_i(eff_add), .eff_mask_i(eff_mask), .eff_shift_i(eff_shift),
    .drop_o(drop), .ins_o(ins_o)
  );

  assign tick_o = tick_i && !drop;

  a_r2_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i);
endmodule

// File: tb/cal_pulse_trim_bench.sv
module cal_pulse_trim_bench;
  localparam int WL = 13;
  localparam int MW = 9;
  localparam int SW = WL - MW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, add_i = 1'b0, win8_i = 1'b0, win16_i = 1'b0;
  logic [MW-1:0] mask_i = '0;
  logic tick_o, ins_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_pulse_trim #(.WIN_LOG(WL), .MASK_W(MW)) u_cal_pulse_trim (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .add_i(add_i),
    .mask_i(mask_i), .win8_i(win8_i), .win16_i(win16_i),
    .tick_o(tick_o), .ins_o(ins_o)
  );

  typedef struct {
    int    len;
    int    drops;
    int    ins;
    int    drop_gap;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one window of enables, optional idle cycles and a mid-window change
  task automatic run_win(input bit a, input int m, input bit w8, input bit w16,
                         input int idle, input string tag, input bit chg = 0,
                         input bit na = 0, input int nm = 0, input bit n8 = 0, input bit n16 = 0);
    exp_t e;
    int s;
    s = w8 ? 2 : (w16 ? 1 : 0);
    e.len = 1 << (WL - s);
    e.drops = m >> s;
    e.ins = a ? (1 << (MW - s)) : 0;
    e.drop_gap = (m == 256 && s == 0) ? (2 << SW) : 0;
    e.tag = tag;
    q.push_back(e);
    for (int k = 0; k < e.len; k++) begin
      if (idle > 0 && k % idle == 0) begin
        @(negedge clk);
        tick_i = 1'b0;
      end
      @(negedge clk);
      tick_i = 1'b1;
      if (k == 0) begin
        add_i = a; mask_i = MW'(m); win8_i = w8; win16_i = w16;
      end
      if (chg && k == e.len / 2) begin
        add_i = na; mask_i = MW'(nm); win8_i = n8; win16_i = n16;
      end
    end
  endtask

  // monitor: tallies one window at a time and compares with the queue head
  int tcnt = 0, dcnt = 0, icnt = 0, idle_bad = 0, gap_bad = 0, ins_gap_bad = 0;
  int last_drop = -1, last_ins = -1;
  always @(negedge clk) begin
    #2;
    if (rst_ni && q.size() > 0) begin
      if (!tick_i) begin
        if (tick_o || ins_o) idle_bad++;
      end else begin
        if (!tick_o) begin
          if (q[0].drop_gap != 0 && last_drop >= 0 && tcnt - last_drop != q[0].drop_gap) gap_bad++;
          last_drop = tcnt;
          dcnt++;
        end
        if (ins_o) begin
          if (last_ins >= 0 && tcnt - last_ins != (1 << SW)) ins_gap_bad++;
          if (!tick_o) ins_gap_bad++;
          last_ins = tcnt;
          icnt++;
        end
        tcnt++;
        if (tcnt == q[0].len) begin
          check(dcnt == q[0].drops, {q[0].tag, " drops"}, dcnt, q[0].drops);
          check(icnt == q[0].ins, {q[0].tag, " inserts"}, icnt, q[0].ins);
          check(idle_bad == 0, {q[0].tag, " R9 idle outputs"}, idle_bad, 0);
          check(ins_gap_bad == 0, {q[0].tag, " R4 insert spacing"}, ins_gap_bad, 0);
          if (q[0].drop_gap != 0) check(gap_bad == 0, {q[0].tag, " R5 drop spacing"}, gap_bad, 0);
          void'(q.pop_front());
          tcnt = 0; dcnt = 0; icnt = 0; idle_bad = 0; gap_bad = 0; ins_gap_bad = 0;
          last_drop = -1; last_ins = -1;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(tick_o == 1'b0 && ins_o == 1'b0, "R1 reset idle", {tick_o, ins_o}, 0);
    tick_i = 1'b1;
    #1;
    check(tick_o == 1'b1 && ins_o == 1'b0, "R1 reset pass", {tick_o, ins_o}, 2);
    @(negedge clk);
    tick_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    run_win(0, 0,   0, 0, 0, "R2 no correction");
    run_win(1, 0,   0, 0, 0, "R4 insert only");
    run_win(0, 511, 0, 0, 0, "R3 full mask");
    run_win(1, 100, 0, 1, 0, "R6 half window");
    run_win(0, 7,   1, 0, 0, "R7 quarter window");
    run_win(1, 300, 0, 0, 4, "R8 R9 change mid-window", 1, 0, 0, 1, 0);
    run_win(0, 0,   1, 0, 0, "R8 new settings next window");
    run_win(0, 511, 1, 1, 0, "R7 quarter priority");
    run_win(0, 256, 0, 0, 0, "R5 even spread");

    @(negedge clk);
    tick_i = 1'b0;
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R3 all windows closed", q.size(), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule